// File: doc/BRIEF.md
# Two-Wire EEPROM Page-Write Slave

This block is the write side of a byte-addressed serial EEPROM on a two-wire bus. It oversamples the bus clock and data lines on the system clock and finds Start and Stop conditions. It shifts in bytes and answers each one on the ninth clock by pulling the data line low through an open-drain enable. A write transfer is made of a device-select byte, a high and a low address byte, and then any number of data bytes. Those data bytes go into a page-sized latch. The offset inside the page advances with every byte and wraps at the page boundary, so later bytes overwrite earlier ones in the same page.

On Stop the latch is copied into the storage array. The copy takes one latch slot per system clock, and it runs inside a busy window of programmable length that stands for the internal programming time. While that window is open the device does not answer its select byte. A write-inhibit input leaves the select and address bytes acknowledged but refuses every data byte, and the refused bytes never reach the latch. A registered read port on the storage array serves the separate read path.

Top module: `eep_page_writer`

## Requirements
- R1: During reset and after it, `sda_oe` is low and the block is idle and not busy. The first device-select byte after reset is acknowledged.
- R2: A device-select byte is acknowledged only when bits 7:4 are 4'b1010, bits 3:1 equal `chip_en` and bit 0 (read/write) is 0. Any other byte gets a NoAck, and every later byte gets a NoAck until the next Start.
- R3: Both address bytes are acknowledged. The byte address is formed from bits 6:0 of the high byte, followed by all 8 bits of the low byte. Bit 7 of the high byte is ignored, and the storage array is indexed by the low `STORE_AW` bits of that address.
- R4: While `wr_ctrl` is low, each data byte is acknowledged and latched at the current page offset. Only the low `PAGE_AW` address bits then increment. After the last slot the offset wraps to 0 of the same page, and later bytes overwrite earlier ones.
- R5: While `wr_ctrl` is high, each data byte gets a NoAck and no storage location changes. The select and address bytes are still acknowledged.
- R6: A Stop that follows at least one latched data byte commits the latch to storage. Only the offsets actually received are written, and no other location changes.
- R7: For `BUSY_CYC` clocks after a committing Stop (at least one clock per page slot), a device-select byte gets a NoAck. After the window ends it is acknowledged again.
- R8: A Start in the middle of a transfer drops the latched bytes without writing them. A Stop that arrives before the data phase commits nothing and opens no busy window.
- R9: `sda_oe` is asserted only while SCL is low: it is set at the SCL fall that ends bit 8 and cleared at the SCL fall that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| chip_en | input | 3 | Strapped chip-enable value compared with select bits 3:1 |
| wr_ctrl | input | 1 | High inhibits data writes and refuses data bytes |
| rd_addr | input | STORE_AW | Storage read address for the read path |
| rd_data | output | 8 | Storage byte at `rd_addr`, one clock later |

## Verification
The bench targets the page boundary. It writes three bytes from offset 62, then checks that the third byte lands at offset 0 of the same page while offset 1 and the first slot of the next page keep their earlier values. A design that carried the increment into the page bits would corrupt the next page instead. Other tests open a transfer and then abort it with a repeated Start, or end it with a Stop before the address is complete. A design that committed stale latch contents there would change memory or stay busy and refuse the next select byte. The bench also probes the select byte inside the busy window, a data byte with `wr_ctrl` high, a wrong chip-enable value and a read-direction select, each of which a careless design would acknowledge.

// File: rtl/eep_pkg.sv
// Shared types and constants for the page-write EEPROM slave.
package eep_pkg;

    // Transfer phase of the slave; PH_IDLE ignores the bus until Start.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_t;

    // Fixed device-type code expected in select bits 7:4.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eep_bus_sync.sv
// Bus line conditioner.
// Brings SCL and SDA into the clk domain through two flops each, then keeps
// one more stage so that edges and Start/Stop conditions can be seen.
// Assumes the bus is slower than clk by several cycles per phase.
module eep_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, sda_m, scl_d, sda_d;

    // Two-flop synchroniser plus a delay stage; an idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
            sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode on the synchronised lines.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/eep_page_latch.sv
// Page latch: one byte and one valid flag per page slot.
// Written during the data phase, read slot by slot during the commit.
// Assumes that clear and writes never occur while the commit is running.
module eep_page_latch #(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               we,
    input  logic [PAGE_AW-1:0] waddr,
    input  logic [7:0]         wdata,
    input  logic [PAGE_AW-1:0] raddr,
    output logic [7:0]         rdata,
    output logic               rvalid,
    input  logic               busy_i
);
    localparam int SLOTS = 1 << PAGE_AW;

    logic [7:0]       slot [SLOTS];
    logic [SLOTS-1:0] valid;

    // Data storage for the slots; no reset is needed because valid gates use.
    always_ff @(posedge clk) begin
        if (we) slot[waddr] <= wdata;
    end

    // Valid flags: cleared at a new transfer, set per received slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) valid <= '0;
        else if (we)         valid[waddr] <= 1'b1;
    end

    // Asynchronous read used by the commit sequencer.
    always_comb begin
        rdata  = slot[raddr];
        rvalid = valid[raddr];
    end

    // R6: the latch contents stay frozen while the commit reads them.
    p_frozen_in_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> valid == $past(valid));
endmodule

// File: rtl/eep_store.sv
// Byte storage array with one write port and one registered read port.
// Contents are not reset; the depth is 2**AW bytes.
module eep_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Commit write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port serving the read path.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/eep_page_writer.sv
// Page-write EEPROM slave, top level.
// Receives select, address and data bytes and acknowledges them through the
// open-drain enable. Data goes into a page latch that wraps within the page.
// On Stop the latch is copied into storage during a busy window.
// Assumes STORE_AW in 9..15 and PAGE_AW below 8.
module eep_page_writer #(
    parameter int STORE_AW = 11,
    parameter int PAGE_AW  = 6,
    parameter int BUSY_CYC = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [2:0]          chip_en,
    input  logic                wr_ctrl,
    input  logic [STORE_AW-1:0] rd_addr,
    output logic [7:0]          rd_data
);
    import eep_pkg::*;

    localparam int SLOTS    = 1 << PAGE_AW;
    localparam int HI_W     = STORE_AW - 8;
    localparam int PG_W     = STORE_AW - PAGE_AW;
    localparam int BUSY_LEN = (BUSY_CYC < SLOTS) ? SLOTS : BUSY_CYC;
    localparam int BUSY_W   = $clog2(BUSY_LEN + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    phase_t               phase, nxt;
    logic [7:0]           shreg;
    logic [2:0]           bit_cnt;
    logic                 byte_rdy, in_ack, got_data;
    logic [STORE_AW-1:0]  addr_q;
    logic [BUSY_W-1:0]    busy_cnt;
    logic                 busy, committing;
    logic [PAGE_AW-1:0]   commit_idx;
    logic [PG_W-1:0]      commit_page;
    logic                 eval, dev_ok, ack_now, lat_we, lat_clr, commit_go;
    logic [7:0]           lat_rdata;
    logic                 lat_rvalid, st_we;

    eep_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    // Byte evaluation: the acknowledge decision and the next phase.
    always_comb begin
        eval    = byte_rdy && scl_fall && (phase != PH_IDLE);
        dev_ok  = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_en)
                  && !shreg[0] && !busy;
        ack_now = 1'b0;
        nxt     = phase;
        case (phase)
            PH_DEV:  begin ack_now = dev_ok; nxt = dev_ok ? PH_AHI : PH_IDLE; end
            PH_AHI:  begin ack_now = 1'b1;   nxt = PH_ALO;  end
            PH_ALO:  begin ack_now = 1'b1;   nxt = PH_DATA; end
            PH_DATA: begin ack_now = !wr_ctrl; end
            default: nxt = PH_IDLE;
        endcase
        lat_we    = eval && (phase == PH_DATA) && !wr_ctrl;
        lat_clr   = eval && (phase == PH_DEV) && dev_ok;
        commit_go = stop_det && (phase == PH_DATA) && got_data;
    end

    // Transfer sequencer: bit shifting, acknowledge drive and phase tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE; shreg <= '0; bit_cnt <= '0;
            byte_rdy <= 1'b0; in_ack <= 1'b0; sda_oe <= 1'b0;
        end else if (start_det) begin
            phase <= PH_DEV; bit_cnt <= '0;
            byte_rdy <= 1'b0; in_ack <= 1'b0; sda_oe <= 1'b0;
        end else if (stop_det) begin
            phase <= PH_IDLE; bit_cnt <= '0;
            byte_rdy <= 1'b0; in_ack <= 1'b0; sda_oe <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (scl_rise && !in_ack && !byte_rdy) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) byte_rdy <= 1'b1;
            end
            if (eval) begin
                byte_rdy <= 1'b0;
                in_ack   <= 1'b1;
                sda_oe   <= ack_now;
                phase    <= nxt;
            end else if (scl_fall && in_ack) begin
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end
        end
    end

    // Address register: the high and low bytes, then an in-page increment per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (eval && phase == PH_AHI) begin
            addr_q[STORE_AW-1:8] <= shreg[HI_W-1:0];
        end else if (eval && phase == PH_ALO) begin
            addr_q[7:0] <= shreg;
        end else if (lat_we) begin
            addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + 1'b1;
        end
    end

    // Tracks whether the current transfer has latched any data byte.
    always_ff @(posedge clk) begin
        if (!rst_n || lat_clr) got_data <= 1'b0;
        else if (lat_we)       got_data <= 1'b1;
    end

    // Busy window and commit sequencer: one latch slot per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0; committing <= 1'b0;
            commit_idx <= '0; commit_page <= '0;
        end else if (commit_go) begin
            busy_cnt    <= BUSY_W'(BUSY_LEN);
            committing  <= 1'b1;
            commit_idx  <= '0;
            commit_page <= addr_q[STORE_AW-1:PAGE_AW];
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (committing) begin
                commit_idx <= commit_idx + 1'b1;
                if (commit_idx == PAGE_AW'(SLOTS - 1)) committing <= 1'b0;
            end
        end
    end

    assign busy  = (busy_cnt != '0);
    assign st_we = committing && lat_rvalid;

    eep_page_latch #(.PAGE_AW(PAGE_AW)) u_latch (
        .clk(clk), .rst_n(rst_n), .clear(lat_clr), .we(lat_we),
        .waddr(addr_q[PAGE_AW-1:0]), .wdata(shreg),
        .raddr(commit_idx), .rdata(lat_rdata), .rvalid(lat_rvalid),
        .busy_i(busy)
    );

    eep_store #(.AW(STORE_AW)) u_store (
        .clk(clk), .we(st_we), .waddr({commit_page, commit_idx}),
        .wdata(lat_rdata), .raddr(rd_addr), .rdata(rd_data)
    );

    // R1: reset leaves the data line released.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);
    // R9: the acknowledge drive only starts while SCL is low.
    p_ack_on_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    // R6: storage is written only inside the busy window.
    p_commit_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> busy);
    // R4: each accepted data byte moves the in-page offset by one, modulo the page.
    p_offset_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lat_we |=> (addr_q[PAGE_AW-1:0] - $past(addr_q[PAGE_AW-1:0])) == PAGE_AW'(1));
    // R7: a select byte seen while busy is never acknowledged.
    p_dev_nack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_DEV) |=> !sda_oe);
endmodule

// File: tb/eep_page_writer_test.sv
// Directed bench for the page-write EEPROM slave; the bench acts as bus master.
module eep_page_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int BUSY       = 400;
    localparam int SAW        = 11;
    localparam int WD_CYCLES  = 150000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scl = 1'b1;
    logic           sda_m = 1'b1;
    logic [2:0]     ce = 3'b101;
    logic           wc = 1'b0;
    logic [SAW-1:0] ra = '0;
    logic [7:0]     rd;
    logic           oe;
    logic           sda_line;
    int             errs = 0;
    int             checks = 0;

    assign sda_line = sda_m & ~oe;

    eep_page_writer #(.STORE_AW(SAW), .PAGE_AW(6), .BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(oe),
        .chip_en(ce), .wr_ctrl(wc), .rd_addr(ra), .rd_data(rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    function automatic logic [7:0] dev(input logic [2:0] c, input logic rw);
        return {4'b1010, c, rw};
    endfunction

    task automatic peek(input int addr, input int exp, input string req);
        ra = SAW'(addr); tick(3);
        chk(req, int'(rd), exp);
    endtask

    // Full write transfer: select, address, n bytes base+i, Stop, commit wait.
    task automatic xfer(input logic [7:0] hi, lo, input int n, input logic [7:0] base,
                        input logic exp_data_ack, input string req);
        logic a;
        bus_start();
        send(dev(ce, 1'b0), a); chk({req, " R2 select ack"}, int'(a), 1);
        send(hi, a);            chk({req, " R3 high address ack"}, int'(a), 1);
        send(lo, a);            chk({req, " R3 low address ack"}, int'(a), 1);
        for (int i = 0; i < n; i++) begin
            send(base + 8'(i), a);
            chk({req, " data ack"}, int'(a), int'(exp_data_ack));
        end
        bus_stop();
        tick(BUSY + 50);
    endtask

    task automatic t_reset();
        tick(2);
        chk("R1 sda_oe after reset", int'(oe), 0);
    endtask

    task automatic t_basic();
        xfer(8'h00, 8'h10, 4, 8'h40, 1'b1, "R4 basic");
        for (int i = 0; i < 4; i++) peek(16 + i, 8'h40 + i, "R6 basic readback");
    endtask

    task automatic t_wrap();
        xfer(8'h01, 8'h00, 2, 8'hA0, 1'b1, "R4 prefill page");
        xfer(8'h01, 8'h40, 1, 8'hB0, 1'b1, "R4 prefill next page");
        xfer(8'h01, 8'h3E, 3, 8'hC0, 1'b1, "R4 wrap");
        peek(12'h13E, 8'hC0, "R4 offset 62");
        peek(12'h13F, 8'hC1, "R4 offset 63");
        peek(12'h100, 8'hC2, "R4 wrapped to offset 0");
        peek(12'h101, 8'hA1, "R6 offset 1 untouched");
        peek(12'h140, 8'hB0, "R4 next page untouched");
    endtask

    task automatic t_protect();
        wc = 1'b1;
        xfer(8'h00, 8'h10, 2, 8'h55, 1'b0, "R5 inhibited");
        wc = 1'b0;
        peek(16, 8'h40, "R5 location 0x10 unchanged");
        peek(17, 8'h41, "R5 location 0x11 unchanged");
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send(dev(3'b011, 1'b0), a); chk("R2 wrong chip enable nack", int'(a), 0);
        send(8'h00, a);             chk("R2 ignored until Start", int'(a), 0);
        send(8'h12, a);             chk("R2 ignored until Start", int'(a), 0);
        send(8'h99, a);             chk("R2 ignored until Start", int'(a), 0);
        bus_stop(); tick(BUSY + 50);
        peek(18, 8'h42, "R2 memory unchanged");
        bus_start();
        send(dev(ce, 1'b1), a);     chk("R2 read direction nack", int'(a), 0);
        bus_stop(); tick(20);
    endtask

    task automatic t_busy();
        logic a;
        bus_start();
        send(dev(ce, 1'b0), a); send(8'h00, a); send(8'h20, a);
        send(8'h77, a);         chk("R4 busy setup data ack", int'(a), 1);
        bus_stop();
        bus_start();
        send(dev(ce, 1'b0), a); chk("R7 select during busy nack", int'(a), 0);
        bus_stop();
        tick(BUSY + 100);
        bus_start();
        send(dev(ce, 1'b0), a); chk("R7 select after busy ack", int'(a), 1);
        bus_stop(); tick(20);
        peek(32, 8'h77, "R6 busy-test byte committed");
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send(dev(ce, 1'b0), a); send(8'h00, a); send(8'h12, a);
        send(8'hEE, a);         chk("R8 data ack before restart", int'(a), 1);
        bus_start();
        bus_stop(); tick(BUSY + 50);
        peek(18, 8'h42, "R8 restart discarded latch");
    endtask

    task automatic t_early_stop();
        logic a;
        bus_start();
        send(dev(ce, 1'b0), a); send(8'h00, a);
        bus_stop();
        bus_start();
        send(dev(ce, 1'b0), a); chk("R8 early Stop opens no busy window", int'(a), 1);
        bus_stop(); tick(20);
    endtask

    task automatic t_hibit();
        xfer(8'h83, 8'h05, 1, 8'h3C, 1'b1, "R3 high bit ignored");
        peek(12'h305, 8'h3C, "R3 address bits 6:0 of high byte");
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        tick(5);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wrap();
        t_protect();
        t_mismatch();
        t_busy();
        t_restart();
        t_early_stop();
        t_hibit();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule